// File: doc/BRIEF.md
# Physical Memory Protection Configuration Bank

This block holds the programmable state of a physical-memory-protection unit: one 8-bit configuration byte and one address register per protection entry, plus a three-bit security control register with a lockdown bit, a deny-by-default bit and a lock-bypass bit. Software reaches this state through CSR-style reads and writes, selected by a register class and an index. Configuration bytes are packed into CSR words, with four bytes per 32-bit word. Address registers and the security register each take a whole word.

Every write passes through the lock rules before it lands. The rules depend on the target entry's own lock bit. For address writes they also depend on the lock bit of the following entry when that entry matches in top-of-range mode. When the enhanced-security strap is set, the lockdown and bypass bits take part as well. All stored state goes to the downstream region decoder and permission checker as flat vectors. A one-cycle strobe signals that at least one write was accepted, so that derived bounds can be recomputed.

Top module: `pmp_cfg_bank`

## Requirements
- R1: After reset every configuration byte, every address register and all three security bits read as zero, and `chg_o` is low.
- R2: Configuration byte layout is R=bit0, W=bit1, X=bit2, match mode=bits 4:3 (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), lock=bit7. In configuration word n, byte i (bits 8i+7:8i) maps to entry 4n+i for both reads and writes.
- R3: A configuration or address write that targets an entry index at or beyond `N_ENTRIES` has no effect, and a read of such an index returns zero.
- R4: With `esec_en_i` low, a configuration byte whose stored lock bit is set ignores writes. The other bytes of the same word are still written independently.
- R5: With `esec_en_i` high, a configuration byte write is accepted when any one of these holds: the bypass bit is set; lockdown is clear and the stored byte is unlocked; lockdown is set and the new byte has lock=1 and X=0; lockdown is set and the new byte has lock=0 and RWX other than 3'b110.
- R6: An address register write is dropped while that entry's own lock bit is set.
- R7: An address register write is dropped while the next entry is both locked and in top-of-range mode. A locked next entry in any other mode does not block it.
- R8: The security word has lockdown=bit0, deny-default=bit1 and bypass=bit2. Once set, lockdown and deny-default cannot be cleared by a later write.
- R9: The bypass bit cannot go from 0 to 1 while any entry has its lock bit set. When it is already 1, a write may clear it.
- R10: `chg_o` is high for exactly the one cycle after a write in which at least one configuration byte, address register or the security register was accepted. Without an accepted write, no stored state changes.
- R11: `cfg_o`, `addr_o`, `mml_o`, `mmwp_o` and `rlb_o` continuously present the stored state, with entry e at slice e of each vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| esec_en_i | input | 1 | Enhanced-security strap; enables lockdown and bypass rules |
| csr_valid_i | input | 1 | Access valid |
| csr_we_i | input | 1 | Write enable (read when low) |
| csr_sel_i | input | 2 | Register class: 0 configuration word, 1 address, 2 security, 3 none |
| csr_idx_i | input | IDX_W | Word or entry index |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Combinational read data for sel/idx |
| cfg_o | output | 8*N_ENTRIES | All configuration bytes, entry e at bits 8e+7:8e |
| addr_o | output | XLEN*N_ENTRIES | All address registers |
| mml_o | output | 1 | Lockdown bit |
| mmwp_o | output | 1 | Deny-by-default bit |
| rlb_o | output | 1 | Lock-bypass bit |
| chg_o | output | 1 | One-cycle strobe after an accepted write |

## Verification
The assertions assume that `esec_en_i` is a quasi-static strap and that `csr_sel_i` and `csr_idx_i` are stable while a write is presented. The lock-hold properties compare the cycle before and the cycle after a write edge, so they rely on the strap being steady across that edge. The stimulus changes the strap only in idle cycles between transactions and drives inputs well away from the clock edge. It issues one transaction at a time, so every write has its own strobe cycle before the next begins.

// File: rtl/pmp_cfg_pkg.sv
package pmp_cfg_pkg;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amatch_e;

  localparam int unsigned CFG_R_BIT    = 0;
  localparam int unsigned CFG_W_BIT    = 1;
  localparam int unsigned CFG_X_BIT    = 2;
  localparam int unsigned CFG_LOCK_BIT = 7;

  localparam int unsigned SEC_MML_BIT  = 0;
  localparam int unsigned SEC_MMWP_BIT = 1;
  localparam int unsigned SEC_RLB_BIT  = 2;

  function automatic amatch_e cfg_mode(input logic [7:0] cfg);
    return amatch_e'(cfg[4:3]);
  endfunction

endpackage

// File: rtl/pmp_cfg_lane.sv
module pmp_cfg_lane
  import pmp_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wbyte_i,
  input  logic       esec_en_i,
  input  logic       mml_i,
  input  logic       rlb_i,
  output logic [7:0] cfg_o,
  output logic       acc_o
);

  logic [7:0] cfg_q;
  logic       cur_lock, new_lock, new_x, ok;
  logic [2:0] new_rwx;

  always_comb begin
    cur_lock = cfg_q[CFG_LOCK_BIT];
    new_lock = wbyte_i[CFG_LOCK_BIT];
    new_x    = wbyte_i[CFG_X_BIT];
    new_rwx  = wbyte_i[CFG_X_BIT:CFG_R_BIT];
    if (!esec_en_i) begin
      ok = !cur_lock;
    end else begin
      ok = rlb_i
         | (!mml_i && !cur_lock)
         | (mml_i && new_lock && !new_x)
         | (mml_i && !new_lock && (new_rwx != 3'b110));
    end
    acc_o = wr_i && ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (acc_o) cfg_q <= wbyte_i;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/pmp_addr_lane.sv
module pmp_addr_lane #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            own_lock_i,
  input  logic            nxt_tor_lock_i,
  output logic [XLEN-1:0] addr_o,
  output logic            acc_o
);

  logic [XLEN-1:0] addr_q;

  assign acc_o = wr_i && !own_lock_i && !nxt_tor_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (acc_o) addr_q <= wdata_i;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
  import pmp_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  input  logic       any_lock_i,
  output logic       mml_o,
  output logic       mmwp_o,
  output logic       rlb_o
);

  logic mml_q, mmwp_q, rlb_q;
  logic rlb_may_set;

  // bypass can only be raised while nothing is locked
  assign rlb_may_set = rlb_q || !any_lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mml_q  <= 1'b0;
      mmwp_q <= 1'b0;
      rlb_q  <= 1'b0;
    end else if (wr_i) begin
      mml_q  <= mml_q  | wdata_i[SEC_MML_BIT];
      mmwp_q <= mmwp_q | wdata_i[SEC_MMWP_BIT];
      rlb_q  <= rlb_may_set & wdata_i[SEC_RLB_BIT];
    end
  end

  assign mml_o  = mml_q;
  assign mmwp_o = mmwp_q;
  assign rlb_o  = rlb_q;

endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmp_cfg_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned XLEN      = 32,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      esec_en_i,
  input  logic                      csr_valid_i,
  input  logic                      csr_we_i,
  input  logic [1:0]                csr_sel_i,
  input  logic [IDX_W-1:0]          csr_idx_i,
  input  logic [XLEN-1:0]           csr_wdata_i,
  output logic [XLEN-1:0]           csr_rdata_o,
  output logic [8*N_ENTRIES-1:0]    cfg_o,
  output logic [XLEN*N_ENTRIES-1:0] addr_o,
  output logic                      mml_o,
  output logic                      mmwp_o,
  output logic                      rlb_o,
  output logic                      chg_o
);

  localparam int unsigned BPC = XLEN / 8;

  csr_sel_e sel;
  logic     wr_go;
  logic     sec_wr;
  logic     any_lock;
  logic     chg_q;
  logic     mml, rlb;

  logic [7:0]      cfg_arr  [N_ENTRIES];
  logic [XLEN-1:0] addr_arr [N_ENTRIES];
  logic [N_ENTRIES-1:0] cfg_acc, addr_acc;

  assign sel    = csr_sel_e'(csr_sel_i);
  assign wr_go  = csr_valid_i && csr_we_i;
  assign sec_wr = wr_go && (sel == SEL_SEC);

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    localparam int CsrNum  = e / BPC;
    localparam int ByteSel = e % BPC;

    logic cfg_wr, addr_wr, nxt_tor_lock;

    assign cfg_wr  = wr_go && (sel == SEL_CFG)  && (int'(csr_idx_i) == CsrNum);
    assign addr_wr = wr_go && (sel == SEL_ADDR) && (int'(csr_idx_i) == e);

    if (e + 1 < N_ENTRIES) begin : g_nxt
      assign nxt_tor_lock = cfg_arr[e+1][CFG_LOCK_BIT] &&
                            (cfg_mode(cfg_arr[e+1]) == AM_TOR);
    end else begin : g_last
      assign nxt_tor_lock = 1'b0;
    end

    pmp_cfg_lane u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (cfg_wr),
      .wbyte_i   (csr_wdata_i[ByteSel*8 +: 8]),
      .esec_en_i (esec_en_i),
      .mml_i     (mml),
      .rlb_i     (rlb),
      .cfg_o     (cfg_arr[e]),
      .acc_o     (cfg_acc[e])
    );

    pmp_addr_lane #(.XLEN(XLEN)) u_addr (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_i           (addr_wr),
      .wdata_i        (csr_wdata_i),
      .own_lock_i     (cfg_arr[e][CFG_LOCK_BIT]),
      .nxt_tor_lock_i (nxt_tor_lock),
      .addr_o         (addr_arr[e]),
      .acc_o          (addr_acc[e])
    );

    assign cfg_o[e*8 +: 8]         = cfg_arr[e];
    assign addr_o[e*XLEN +: XLEN]  = addr_arr[e];
  end

  always_comb begin
    any_lock = 1'b0;
    for (int e = 0; e < N_ENTRIES; e++) any_lock |= cfg_arr[e][CFG_LOCK_BIT];
  end

  pmp_sec_reg u_sec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (sec_wr),
    .wdata_i    (csr_wdata_i[2:0]),
    .any_lock_i (any_lock),
    .mml_o      (mml),
    .mmwp_o     (mmwp_o),
    .rlb_o      (rlb)
  );

  assign mml_o = mml;
  assign rlb_o = rlb;

  always_comb begin
    csr_rdata_o = '0;
    unique case (sel)
      SEL_CFG: begin
        for (int e = 0; e < N_ENTRIES; e++) begin
          if (int'(csr_idx_i) == e / BPC) csr_rdata_o[(e % BPC)*8 +: 8] = cfg_arr[e];
        end
      end
      SEL_ADDR: begin
        for (int e = 0; e < N_ENTRIES; e++) begin
          if (int'(csr_idx_i) == e) csr_rdata_o = addr_arr[e];
        end
      end
      SEL_SEC: begin
        csr_rdata_o[SEC_MML_BIT]  = mml;
        csr_rdata_o[SEC_MMWP_BIT] = mmwp_o;
        csr_rdata_o[SEC_RLB_BIT]  = rlb;
      end
      default: csr_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= (|cfg_acc) || (|addr_acc) || sec_wr;
  end

  assign chg_o = chg_q;

endmodule

// File: rtl/pmp_cfg_bank_chk.sv
module pmp_cfg_bank_chk #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned XLEN      = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      esec_en_i,
  input logic                      csr_valid_i,
  input logic                      csr_we_i,
  input logic [1:0]                csr_sel_i,
  input logic [8*N_ENTRIES-1:0]    cfg_o,
  input logic [XLEN*N_ENTRIES-1:0] addr_o,
  input logic                      mml_o,
  input logic                      mmwp_o,
  input logic                      rlb_o,
  input logic                      chg_o
);

  logic any_lock_c;
  always_comb begin
    any_lock_c = 1'b0;
    for (int e = 0; e < N_ENTRIES; e++) any_lock_c |= cfg_o[e*8+7];
  end

  // R8
  mml_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mml_o |=> mml_o);

  // R8
  mmwp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmwp_o |=> mmwp_o);

  // R9
  rlb_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rlb_o) |-> !$past(any_lock_c));

  // R10
  chg_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_valid_i && csr_we_i) |=> !chg_o);

  // R10
  sec_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && csr_we_i && csr_sel_i == 2'd2) |=> chg_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(csr_valid_i && csr_we_i) |=> ($stable(cfg_o) && $stable(addr_o)));

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_chk
    // R4
    cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!esec_en_i && cfg_o[e*8+7]) |=> $stable(cfg_o[e*8 +: 8]));

    // R6
    addr_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_o[e*8+7] |=> $stable(addr_o[e*XLEN +: XLEN]));

    if (e + 1 < N_ENTRIES) begin : g_tor
      // R7
      tor_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_o[(e+1)*8+7] && cfg_o[(e+1)*8+3 +: 2] == 2'd1)
          |=> $stable(addr_o[e*XLEN +: XLEN]));
    end
  end

endmodule

bind pmp_cfg_bank pmp_cfg_bank_chk #(
  .N_ENTRIES(N_ENTRIES),
  .XLEN     (XLEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .esec_en_i   (esec_en_i),
  .csr_valid_i (csr_valid_i),
  .csr_we_i    (csr_we_i),
  .csr_sel_i   (csr_sel_i),
  .cfg_o       (cfg_o),
  .addr_o      (addr_o),
  .mml_o       (mml_o),
  .mmwp_o      (mmwp_o),
  .rlb_o       (rlb_o),
  .chg_o       (chg_o)
);

// File: tb/pmp_cfg_bank_tb_top.sv
module pmp_cfg_bank_tb_top;

  localparam int unsigned N_ENTRIES = 8;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned IDX_W     = 5;

  localparam logic [1:0] S_CFG  = 2'd0;
  localparam logic [1:0] S_ADDR = 2'd1;
  localparam logic [1:0] S_SEC  = 2'd2;

  typedef struct {
    logic [XLEN-1:0] exp;
    string           tag;
  } exp_t;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic                      esec_en = 1'b0;
  logic                      valid = 1'b0;
  logic                      we = 1'b0;
  logic [1:0]                sel = 2'd3;
  logic [IDX_W-1:0]          idx = '0;
  logic [XLEN-1:0]           wdata = '0;
  logic [XLEN-1:0]           rdata;
  logic [8*N_ENTRIES-1:0]    cfg_v;
  logic [XLEN*N_ENTRIES-1:0] addr_v;
  logic                      mml, mmwp, rlb, chg;

  int   errs = 0;
  int   checks = 0;
  exp_t rd_q[$];
  exp_t chg_q[$];
  logic rd_act = 1'b0;
  logic chg_act = 1'b0;
  exp_t cur;

  always #5 clk = ~clk;

  pmp_cfg_bank #(
    .N_ENTRIES(N_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .esec_en_i(esec_en),
    .csr_valid_i(valid), .csr_we_i(we), .csr_sel_i(sel),
    .csr_idx_i(idx), .csr_wdata_i(wdata), .csr_rdata_o(rdata),
    .cfg_o(cfg_v), .addr_o(addr_v), .mml_o(mml), .mmwp_o(mmwp),
    .rlb_o(rlb), .chg_o(chg)
  );

  // monitor: compares at the falling edge, away from driver activity
  always @(negedge clk) begin
    if (rd_act) begin
      cur = rd_q.pop_front();
      checks++;
      if (rdata !== cur.exp) begin
        errs++;
        $display("FAIL %s rdata=%h expected=%h", cur.tag, rdata, cur.exp);
      end
      rd_act = 1'b0;
    end
    if (chg_act) begin
      cur = chg_q.pop_front();
      checks++;
      if (chg !== cur.exp[0]) begin
        errs++;
        $display("FAIL %s chg=%b expected=%b", cur.tag, chg, cur.exp[0]);
      end
      chg_act = 1'b0;
    end
  end

  task automatic do_wr(input logic [1:0] s, input int i, input logic [XLEN-1:0] d,
                       input logic exp_chg, input string tag);
    @(posedge clk); #1;
    valid = 1'b1; we = 1'b1; sel = s; idx = IDX_W'(i); wdata = d;
    @(posedge clk); #1;
    valid = 1'b0; we = 1'b0;
    chg_q.push_back('{exp: XLEN'(exp_chg), tag: tag});
    chg_act = 1'b1;
  endtask

  task automatic do_rd(input logic [1:0] s, input int i, input logic [XLEN-1:0] e,
                       input string tag);
    @(posedge clk); #1;
    valid = 1'b1; we = 1'b0; sel = s; idx = IDX_W'(i);
    rd_q.push_back('{exp: e, tag: tag});
    rd_act = 1'b1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    valid = 1'b0; we = 1'b0; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    do_rd(S_CFG, 0, 32'h0, "R1 cfg0");
    do_rd(S_CFG, 1, 32'h0, "R1 cfg1");
    do_rd(S_ADDR, 0, 32'h0, "R1 addr0");
    do_rd(S_SEC, 0, 32'h0, "R1 sec");
    @(posedge clk); #1;
    checks++;
    if (chg !== 1'b0) begin errs++; $display("FAIL R1 chg=%b expected=0", chg); end

    // R2 packing, R11 export
    do_wr(S_CFG, 0, 32'h101F0B01, 1'b1, "R10 cfg accept");
    do_rd(S_CFG, 0, 32'h101F0B01, "R2 cfg0 packed");
    do_rd(S_CFG, 1, 32'h0, "R2 cfg1 untouched");
    @(posedge clk); #1;
    checks++;
    if (cfg_v[15:8] !== 8'h0B) begin errs++; $display("FAIL R11 cfg_o[1]=%h expected=0b", cfg_v[15:8]); end

    // R3 out of range
    do_wr(S_CFG, 2, 32'hFFFFFFFF, 1'b0, "R3 cfg oor chg");
    do_rd(S_CFG, 2, 32'h0, "R3 cfg oor read");
    do_wr(S_ADDR, 9, 32'hDEAD, 1'b0, "R3 addr oor chg");
    do_rd(S_ADDR, 9, 32'h0, "R3 addr oor read");
    do_rd(S_CFG, 1, 32'h0, "R3 no alias");

    // R4 locked byte ignored, neighbours written
    do_wr(S_CFG, 0, 32'h101F8B01, 1'b1, "R4 lock set");
    do_wr(S_CFG, 0, 32'h00000000, 1'b1, "R4 partial accept chg");
    do_rd(S_CFG, 0, 32'h00008B00, "R4 locked byte kept");

    // R6 own lock, R7 next TOR lock
    do_wr(S_ADDR, 1, 32'h1234, 1'b0, "R6 drop chg");
    do_rd(S_ADDR, 1, 32'h0, "R6 own lock");
    do_wr(S_ADDR, 0, 32'h55, 1'b0, "R7 tor drop chg");
    do_rd(S_ADDR, 0, 32'h0, "R7 next tor lock");
    do_wr(S_ADDR, 2, 32'hAA, 1'b1, "R6 unlocked chg");
    do_rd(S_ADDR, 2, 32'hAA, "R6 unlocked write");
    @(posedge clk); #1;
    checks++;
    if (addr_v[2*XLEN +: XLEN] !== 32'hAA) begin
      errs++; $display("FAIL R11 addr_o[2]=%h expected=aa", addr_v[2*XLEN +: XLEN]);
    end
    do_wr(S_CFG, 1, 32'h00009000, 1'b1, "R7 na4 lock set");
    do_wr(S_ADDR, 4, 32'h77, 1'b1, "R7 non-tor chg");
    do_rd(S_ADDR, 4, 32'h77, "R7 non-tor next lock");

    // R9 bypass refused while locked
    do_wr(S_SEC, 0, 32'h4, 1'b1, "R10 sec chg");
    do_rd(S_SEC, 0, 32'h0, "R9 rlb blocked");

    // R5 enhanced, lockdown clear, locked byte refused
    @(posedge clk); #1 esec_en = 1'b1;
    do_wr(S_CFG, 0, 32'h00000B00, 1'b1, "R5 partial chg");
    do_rd(S_CFG, 0, 32'h00008B00, "R5 locked no mml");

    // second phase
    do_reset();
    do_rd(S_CFG, 0, 32'h0, "R1 after reset");
    do_wr(S_SEC, 0, 32'h4, 1'b1, "R9 rlb set chg");
    do_rd(S_SEC, 0, 32'h4, "R9 rlb set unlocked");
    do_wr(S_CFG, 0, 32'h00000080, 1'b1, "R5 lock");
    do_wr(S_CFG, 0, 32'h00000001, 1'b1, "R5 bypass chg");
    do_rd(S_CFG, 0, 32'h00000001, "R5 bypass write");
    do_wr(S_SEC, 0, 32'h0, 1'b1, "R9 clear chg");
    do_rd(S_SEC, 0, 32'h0, "R9 rlb clear");

    do_wr(S_CFG, 0, 32'h00008B00, 1'b1, "R5 lock entry1");
    do_wr(S_SEC, 0, 32'h1, 1'b1, "R8 mml chg");
    do_rd(S_SEC, 0, 32'h1, "R8 mml set");
    do_wr(S_SEC, 0, 32'h0, 1'b1, "R8 clr chg");
    do_rd(S_SEC, 0, 32'h1, "R8 mml sticky");
    do_wr(S_SEC, 0, 32'h2, 1'b1, "R8 mmwp chg");
    do_rd(S_SEC, 0, 32'h3, "R8 mmwp set");
    do_wr(S_SEC, 0, 32'h0, 1'b1, "R8 clr2 chg");
    do_rd(S_SEC, 0, 32'h3, "R8 both sticky");

    do_wr(S_CFG, 0, 32'h00000600, 1'b1, "R5 wx chg");
    do_rd(S_CFG, 0, 32'h00008B00, "R5 mml wx refused");
    do_wr(S_CFG, 0, 32'h00008500, 1'b1, "R5 lx chg");
    do_rd(S_CFG, 0, 32'h00008B00, "R5 mml lock+x refused");
    do_wr(S_CFG, 0, 32'h00008300, 1'b1, "R5 l chg");
    do_rd(S_CFG, 0, 32'h00008300, "R5 mml lock no x");
    do_wr(S_CFG, 0, 32'h00000300, 1'b1, "R5 unl chg");
    do_rd(S_CFG, 0, 32'h00000300, "R5 mml unlock rw");
    do_wr(S_CFG, 0, 32'h00000306, 1'b1, "R5 mixed chg");
    do_rd(S_CFG, 0, 32'h00000300, "R5 mml shared wx byte0");

    @(posedge clk); #1 valid = 1'b0;
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule